// File: doc/BRIEF.md
# Pixel colour-space matrix (RGB to YCbCr)

This block converts a stream of 24-bit RGB pixels into BT.601 limited-range YCbCr on the way to a display output. Each output channel is an affine function of the three input channels: three signed multipliers plus a signed offset, one set of four per output row. That makes twelve programmable terms, and their reset values encode the standard RGB to YCbCr conversion. A single enable bit chooses between the matrix result and an unmodified copy of the input pixel.

Configuration writes go to a staging copy of the twelve terms and of the enable bit. The staging copy becomes active only when a start-of-frame pixel is accepted, so every pixel of one frame uses one consistent set. The pixel side is a valid/ready stream with a start-of-frame flag and a small sideband field. Both travel with the pixel through a fixed three-stage pipeline. When the consumer stalls, the whole pipeline stalls.

Top module: `csc_top`

## Requirements
- R1: After reset, out_valid is low and in_ready is high. The enable bit resets to 0, so the first frame passes through unchanged. All twelve terms reset to their default values.
- R2: While the active enable bit is 0, out_data equals the accepted in_data bit for bit.
- R3: While the active enable bit is 1, output channel k is floor((M0*R + M1*G + M2*B + OFS*64) / 1024), where M0..M2 and OFS are the four terms of row k. Both kinds of term are 14-bit two's complement; multipliers have 10 fraction bits and offsets have 4. R is in_data[23:16], G is in_data[15:8] and B is in_data[7:0]. Row 0 drives out_data[23:16] (Y), row 1 drives [15:8] (Cb) and row 2 drives [7:0] (Cr).
- R4: A channel result below 0 is output as 0, and a result above 255 is output as 255.
- R5: The default terms, listed per row as multipliers then offset, are: row 0 = 0x107, 0x204, 0x064, 0x108; row 1 = 0x3F69, 0x3ED6, 0x1C1, 0x808; row 2 = 0x1C1, 0x3E88, 0x3FB8, 0x808. With these, white maps to (235,128,128) and black to (16,128,128).
- R6: A write at cfg_addr = 4*row + col sets one term, where col 3 is the offset. A write at address 12 sets the enable bit from cfg_wdata[0]. Writes to addresses 13 to 15 have no effect.
- R7: Writes update only the staged copy. Accepting a pixel with in_sof = 1 copies the staged terms and the staged enable into the active set, and that pixel already uses the new set. Pixels accepted without in_sof use the previous active set.
- R8: A pixel accepted on a rising edge appears on the outputs after the third rising edge, counting the accepting edge, when out_ready stays high. out_sof and out_side carry that pixel's in_sof and in_side.
- R9: While out_valid is high and out_ready is low, all outputs hold steady and in_ready is low, so no input pixel is taken.
- R10: Clearing the enable bit does not alter the stored terms. Setting it again at a later frame start restores the same matrix results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (4) | Configuration word select |
| cfg_wdata | input | COEF_W (14) | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel |
| in_sof | input | 1 | Input pixel starts a frame |
| in_side | input | SIDE_W (2) | Sideband carried with the pixel |
| in_data | input | 3*PIX_W (24) | Input pixel, R G B from the top down |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_sof | output | 1 | Output pixel starts a frame |
| out_side | output | SIDE_W (2) | Delayed sideband |
| out_data | output | 3*PIX_W (24) | Output pixel, Y Cb Cr (or bypassed RGB) |

## Verification
The matrix is driven with white, black, saturated primaries and mid-grey. White and black pin down the default offsets and the floor rounding. The primaries separate the three multipliers of each row, so a swapped channel or a swapped coefficient shows up. Custom terms with extreme positive and negative values push a row past both clamp limits. Pixels sent with and without a frame-start flag, around staged writes, distinguish staged state from active state and show whether the enable bit keeps the stored matrix intact.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int NROW       = 3;
  localparam int NTERM      = 4;
  localparam int NCOEF      = NROW * NTERM;
  localparam int CFG_EN_ADDR = NCOEF;

  // reset matrix: RGB to BT.601 limited-range YCbCr
  function automatic logic [15:0] default_coef(input int idx);
    case (idx)
      0:  return 16'h0107;
      1:  return 16'h0204;
      2:  return 16'h0064;
      3:  return 16'h0108;
      4:  return 16'h3F69;
      5:  return 16'h3ED6;
      6:  return 16'h01C1;
      7:  return 16'h0808;
      8:  return 16'h01C1;
      9:  return 16'h3E88;
      10: return 16'h3FB8;
      11: return 16'h0808;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
  import csc_pkg::*;
#(
  parameter int COEF_W = 14,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  input  logic              load,
  output logic [COEF_W-1:0] use_coef [NCOEF],
  output logic              use_en,
  output logic [COEF_W-1:0] act_coef [NCOEF],
  output logic              act_en
);
  logic [COEF_W-1:0] stg_q [NCOEF];
  logic [COEF_W-1:0] stg_d [NCOEF];
  logic [COEF_W-1:0] act_q [NCOEF];
  logic [COEF_W-1:0] act_d [NCOEF];
  logic              stg_en_q, stg_en_d, act_en_q, act_en_d;

  always_comb begin
    for (int i = 0; i < NCOEF; i++) begin
      stg_d[i]    = (wr_en && (wr_addr == ADDR_W'(i))) ? wr_data : stg_q[i];
      act_d[i]    = load ? stg_q[i] : act_q[i];
      use_coef[i] = act_d[i];
      act_coef[i] = act_q[i];
    end
    stg_en_d = (wr_en && (wr_addr == ADDR_W'(CFG_EN_ADDR))) ? wr_data[0] : stg_en_q;
    act_en_d = load ? stg_en_q : act_en_q;
    use_en   = act_en_d;
    act_en   = act_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) begin
        stg_q[i] <= COEF_W'(default_coef(i));
        act_q[i] <= COEF_W'(default_coef(i));
      end
      stg_en_q <= 1'b0;
      act_en_q <= 1'b0;
    end else begin
      stg_q    <= stg_d;
      act_q    <= act_d;
      stg_en_q <= stg_en_d;
      act_en_q <= act_en_d;
    end
  end
endmodule

// File: rtl/csc_row.sv
module csc_row #(
  parameter int PIX_W    = 8,
  parameter int COEF_W   = 14,
  parameter int FRAC     = 10,
  parameter int OFF_FRAC = 4
) (
  input  logic              clk,
  input  logic              adv,
  input  logic [PIX_W-1:0]  px [3],
  input  logic [COEF_W-1:0] cf [4],
  output logic [PIX_W-1:0]  res
);
  localparam int PROD_W = PIX_W + 1 + COEF_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam int OFF_SH = FRAC - OFF_FRAC;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

  logic signed [PROD_W-1:0] prod_d [3];
  logic signed [PROD_W-1:0] prod_q [3];
  logic signed [SUM_W-1:0]  off_d, off_q, sum_d, sum_q, quo;

  always_comb begin
    for (int k = 0; k < 3; k++)
      prod_d[k] = PROD_W'($signed({1'b0, px[k]})) * PROD_W'($signed(cf[k]));
    off_d = SUM_W'($signed(cf[3])) <<< OFF_SH;
    sum_d = SUM_W'(prod_q[0]) + SUM_W'(prod_q[1]) + SUM_W'(prod_q[2]) + off_q;
    quo   = sum_q >>> FRAC;
    if (quo < 0)         res = '0;
    else if (quo > MAXV) res = '1;
    else                 res = quo[PIX_W-1:0];
  end

  // stage 1: products and aligned offset; stage 2: row sum
  always_ff @(posedge clk) begin
    if (adv) begin
      prod_q <= prod_d;
      off_q  <= off_d;
      sum_q  <= sum_d;
    end
  end
endmodule

// File: rtl/csc_top.sv
module csc_top
  import csc_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int COEF_W   = 14,
  parameter int SIDE_W   = 2,
  parameter int ADDR_W   = 4,
  parameter int FRAC     = 10,
  parameter int OFF_FRAC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [COEF_W-1:0]    cfg_wdata,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_sof,
  input  logic [SIDE_W-1:0]    in_side,
  input  logic [3*PIX_W-1:0]   in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_sof,
  output logic [SIDE_W-1:0]    out_side,
  output logic [3*PIX_W-1:0]   out_data
);
  localparam int DATA_W = NROW * PIX_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic adv, load;
  logic v1_q, v2_q, v3_q, v1_d, v2_d, v3_d;
  logic byp1_q, byp2_q, sof1_q, sof2_q, sof3_q;
  logic [SIDE_W-1:0] side1_q, side2_q, side3_q;
  logic [DATA_W-1:0] pix1_q, pix2_q, out_q, out_d, mat_w;

  logic [COEF_W-1:0] use_coef [NCOEF];
  logic [COEF_W-1:0] act_coef [NCOEF];
  logic              use_en, act_en;
  logic [NCOEF*COEF_W-1:0] act_flat;
  logic [PIX_W-1:0]  px [3];

  always_comb begin
    adv  = !v3_q || out_ready;
    load = in_valid && adv && in_sof;
    for (int c = 0; c < 3; c++) px[c] = in_data[(2-c)*PIX_W +: PIX_W];
    v1_d  = adv ? in_valid : v1_q;
    v2_d  = adv ? v1_q     : v2_q;
    v3_d  = adv ? v2_q     : v3_q;
    out_d = byp2_q ? pix2_q : mat_w;
  end

  csc_coef_bank #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (cfg_we),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .load     (load),
    .use_coef (use_coef),
    .use_en   (use_en),
    .act_coef (act_coef),
    .act_en   (act_en)
  );

  for (genvar i = 0; i < NCOEF; i++) begin : g_flat
    assign act_flat[i*COEF_W +: COEF_W] = act_coef[i];
  end

  for (genvar r = 0; r < NROW; r++) begin : g_row
    logic [COEF_W-1:0] rcf [NTERM];
    logic [PIX_W-1:0]  rres;
    always_comb for (int t = 0; t < NTERM; t++) rcf[t] = use_coef[r*NTERM + t];
    csc_row #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC(FRAC), .OFF_FRAC(OFF_FRAC)) u_row (
      .clk (clk),
      .adv (adv),
      .px  (px),
      .cf  (rcf),
      .res (rres)
    );
    assign mat_w[(NROW-1-r)*PIX_W +: PIX_W] = rres;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      v3_q <= v3_d;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      byp1_q  <= !use_en;
      pix1_q  <= in_data;
      sof1_q  <= in_sof;
      side1_q <= in_side;
      byp2_q  <= byp1_q;
      pix2_q  <= pix1_q;
      sof2_q  <= sof1_q;
      side2_q <= side1_q;
      out_q   <= out_d;
      sof3_q  <= sof2_q;
      side3_q <= side2_q;
    end
  end

  assign in_ready  = adv;
  assign out_valid = v3_q;
  assign out_data  = out_q;
  assign out_sof   = sof3_q;
  assign out_side  = side3_q;
endmodule

// File: rtl/csc_chk.sv
module csc_chk #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 14,
  parameter int SIDE_W = 2,
  parameter int NCOEF  = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   in_sof,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic                   out_sof,
  input logic [SIDE_W-1:0]      out_side,
  input logic [3*PIX_W-1:0]     out_data,
  input logic [NCOEF*COEF_W-1:0] act_flat,
  input logic                   act_en
);
  // R9: a stalled output holds every field
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_side));

  // R8: an accepted pixel reaches the output after three edges without stall
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready ##1 out_ready |=> out_valid);

  // R7: the active terms change only when a frame-start pixel is taken
  p_frame_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && in_sof) |=> $stable(act_flat));

  // R10: the active enable changes only at a frame start
  p_enable_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && in_sof) |=> $stable(act_en));
endmodule

bind csc_top csc_chk #(
  .PIX_W (PIX_W),
  .COEF_W(COEF_W),
  .SIDE_W(SIDE_W),
  .NCOEF (csc_pkg::NCOEF)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_sof   (in_sof),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_sof  (out_sof),
  .out_side (out_side),
  .out_data (out_data),
  .act_flat (act_flat),
  .act_en   (act_en)
);

// File: tb/tb_csc_top.sv
module tb_csc_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [13:0] cfg_wdata;
  logic        in_valid, in_ready, in_sof;
  logic [1:0]  in_side;
  logic [23:0] in_data;
  logic        out_valid, out_ready, out_sof;
  logic [1:0]  out_side;
  logic [23:0] out_data;

  int total = 0;
  int bad   = 0;

  int stg [12];
  int act [12];
  logic stg_en, act_en;

  csc_top dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_side(in_side), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof),
    .out_side(out_side), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int sx(input int raw);
    return (raw >= 8192) ? raw - 16384 : raw;
  endfunction

  function automatic logic [7:0] chan(input int row, input logic [23:0] p);
    int s, q;
    s = act[row*4]   * int'(p[23:16]) + act[row*4+1] * int'(p[15:8])
      + act[row*4+2] * int'(p[7:0])   + act[row*4+3] * 64;
    q = s >>> 10;
    if (q < 0)   return 8'd0;
    if (q > 255) return 8'd255;
    return q[7:0];
  endfunction

  function automatic logic [23:0] model(input logic [23:0] p);
    if (!act_en) return p;
    return {chan(0, p), chan(1, p), chan(2, p)};
  endfunction

  task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic cfg(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 14'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 12) stg[a] = sx(d);
    else if (a == 12) stg_en = d[0];
  endtask

  task automatic send(input logic [23:0] d, input logic sof, input logic [1:0] sd,
                      output logic [23:0] got, output int lat,
                      output logic gsof, output logic [1:0] gside);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = sof; in_side = sd;
    @(posedge clk);
    if (sof) begin act = stg; act_en = stg_en; end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin @(negedge clk); lat++; end
    got = out_data; gsof = out_sof; gside = out_side;
  endtask

  task automatic px_check(input string req, input logic [23:0] d, input logic sof);
    logic [23:0] g; int l; logic s; logic [1:0] sd;
    send(d, sof, 2'b00, g, l, s, sd);
    chk(req, g, model(d));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_bypass;
    px_check("R1 R2 first frame bypass", 24'hFF0000, 1'b1);
    chk("R2 model is identity", act_en, 0);
    px_check("R2 bypass pattern", 24'h123456, 1'b0);
    px_check("R2 bypass pattern", 24'hA5005A, 1'b0);
  endtask

  task automatic t_defaults;
    logic [23:0] g; int l; logic s; logic [1:0] sd;
    cfg(12, 1);
    px_check("R7 enable staged only", 24'h00FF00, 1'b0);
    send(24'hFFFFFF, 1'b1, 2'b00, g, l, s, sd);
    chk("R5 white", g, 24'hEB8080);
    send(24'h000000, 1'b0, 2'b00, g, l, s, sd);
    chk("R5 black", g, 24'h108080);
    px_check("R3 red", 24'hFF0000, 1'b0);
    px_check("R3 green", 24'h00FF00, 1'b0);
    px_check("R3 blue", 24'h0000FF, 1'b0);
    px_check("R3 grey", 24'h808080, 1'b0);
  endtask

  task automatic t_latency;
    logic [23:0] g; int l; logic s; logic [1:0] sd;
    send(24'h3C7A19, 1'b1, 2'b10, g, l, s, sd);
    chk("R8 latency edges", l, 3);
    chk("R8 sof follows", s, 1);
    chk("R8 side follows", sd, 2'b10);
    send(24'h3C7A19, 1'b0, 2'b01, g, l, s, sd);
    chk("R8 sof clear follows", s, 0);
    chk("R8 side follows", sd, 2'b01);
  endtask

  task automatic t_clamp;
    logic [23:0] g; int l; logic s; logic [1:0] sd;
    for (int i = 0; i < 3; i++) cfg(i, 14'h1FFF);
    cfg(3, 0);
    for (int i = 4; i < 7; i++) cfg(i, 14'h2000);
    cfg(7, 0);
    send(24'h808080, 1'b1, 2'b00, g, l, s, sd);
    chk("R4 clamp high", g[23:16], 8'd255);
    chk("R4 clamp low", g[15:8], 8'd0);
    chk("R4 row2 unchanged", g[7:0], model(24'h808080) & 24'hFF);
  endtask

  task automatic t_map;
    for (int a = 13; a < 16; a++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 14'h3FFF;
    end
    @(negedge clk); cfg_we = 1'b0;
    for (int i = 0; i < 8; i++) cfg(i, int'(csc_pkg::default_coef(i)));
    px_check("R6 unused addresses ignored", 24'h40C020, 1'b1);
    cfg(8, 14'h0200);
    cfg(11, 14'h0100);
    px_check("R6 row2 terms by address", 24'h204060, 1'b1);
    px_check("R6 row2 terms by address", 24'hFF8000, 1'b0);
  endtask

  task automatic t_frame;
    logic [23:0] g, prev; int l; logic s; logic [1:0] sd;
    send(24'hFF0000, 1'b0, 2'b00, prev, l, s, sd);
    cfg(0, 0);
    send(24'hFF0000, 1'b0, 2'b00, g, l, s, sd);
    chk("R7 mid-frame write held back", g, prev);
    send(24'hFF0000, 1'b1, 2'b00, g, l, s, sd);
    chk("R7 applied at frame start", g, model(24'hFF0000));
    chk("R7 Y changed", (g[23:16] != prev[23:16]), 1);
  endtask

  task automatic t_enable;
    cfg(12, 0);
    px_check("R10 disabled bypass", 24'h9911EE, 1'b1);
    cfg(12, 1);
    px_check("R10 matrix restored", 24'h9911EE, 1'b1);
    px_check("R10 matrix restored", 24'h2277CC, 1'b0);
  endtask

  task automatic t_backpressure;
    logic [23:0] e1;
    int l;
    e1 = model(24'h5A3C96);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 24'h5A3C96; in_sof = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 output waiting", out_valid, 1);
    chk("R9 data under stall", out_data, e1);
    chk("R9 in_ready low", in_ready, 0);
    in_valid = 1'b1; in_data = 24'h10E0F0;
    repeat (3) @(negedge clk);
    chk("R9 data held", out_data, e1);
    chk("R9 still not ready", in_ready, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    l = 1;
    while (!out_valid && l < 20) begin @(negedge clk); l++; end
    chk("R9 queued pixel after release", out_data, model(24'h10E0F0));
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) begin
      stg[i] = sx(int'(csc_pkg::default_coef(i)));
      act[i] = stg[i];
    end
    stg_en = 1'b0; act_en = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_sof = 1'b0; in_side = '0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bypass();
    t_defaults();
    t_latency();
    t_clamp();
    t_map();
    t_frame();
    t_enable();
    t_backpressure();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule